// File: doc/BRIEF.md
# Serial Transmitter with Top-Position Parity

This block serialises data words onto a single transmit line at a rate set by an external one-cycle bit tick. A host loads a word through a write strobe into a holding register. The transmitter moves that word into its shift register and sends a frame made of a low start bit, the data positions least significant bit first, and one high stop bit. A frame carries either 8 or 9 data positions. When parity is switched on, the computed even or odd parity takes the highest data position, so the frame keeps its length and carries one fewer payload bit.

Word length, parity on/off and parity type are captured when a frame starts, so changing them mid-frame only affects later frames. The enable input gates frame starts. After the enable rises from an idle, disabled state, the first tick only arms the transmitter. If the enable drops and rises again while a frame is on the line, one idle frame (line held high for a whole frame time) is inserted after the current frame. Two flags report that the holding register is empty and that transmission is complete. An interrupt output combines them under individual enables.

Top module: `uart_tx_msbpar`

## Requirements
- R1: After reset the line is high, the empty flag and the complete flag are both 1, and the interrupt is 0 while both interrupt enables are 0.
- R2: A data frame is one low start bit, then the data positions least significant first, then one high stop bit. Each bit lasts exactly one tick period, and the line changes in the cycle after a tick.
- R3: word9_i = 1 gives 9 data positions and word9_i = 0 gives 8, taken from wdata_i[8:0] or wdata_i[7:0].
- R4: With par_en_i = 1, the top data position (position 8 in 9-bit frames, position 7 in 8-bit frames) is replaced by a parity bit. With par_odd_i = 0 the count of ones over all data positions is even; with par_odd_i = 1 it is odd.
- R5: word9_i, par_en_i and par_odd_i are sampled when a frame starts. Changing them during the frame leaves that frame unchanged.
- R6: When tx_en_i rises while the transmitter is idle and disarmed, the first tick only arms it. A frame can start no earlier than the following tick.
- R7: A low-then-high sequence on tx_en_i during a frame causes one idle frame after that frame: the line is held high for word-length + 2 bit periods before the next data frame starts.
- R8: If tx_en_i is low at a tick where a frame could start, no frame starts, the line stays high and a pending word stays pending (empty flag stays 0).
- R9: The empty flag goes to 1 in the cycle the pending word enters the shift register, which is the cycle the start bit appears. A write clears it.
- R10: The complete flag goes to 1 when a stop bit ends with no word pending. A write clears it.
- R11: irq_o is 1 exactly when (txe_o and txe_ie_i) or (tc_o and tc_ie_i).
- R12: tx_o never changes except in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per bit period |
| tx_en_i | input | 1 | Transmitter enable |
| word9_i | input | 1 | 1: 9 data positions, 0: 8 |
| par_en_i | input | 1 | Parity in the top data position |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| wr_i | input | 1 | Write strobe for wdata_i |
| wdata_i | input | 9 | Word to send |
| txe_ie_i | input | 1 | Interrupt enable for the empty flag |
| tc_ie_i | input | 1 | Interrupt enable for the complete flag |
| tx_o | output | 1 | Serial line, idles high |
| txe_o | output | 1 | Holding register empty |
| tc_o | output | 1 | Transmission complete |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is the preamble insertion. The enable must go low and then high strictly inside a running frame, while a second word waits in the holding register, and the line must then be watched across the whole following frame time. The stimulus lines up on the start bit of the first frame, writes the second word, and pulses the enable low for one cycle. It then measures the high stretch from the first stop bit to the next start bit. A second hard case changes the frame configuration halfway through a frame, right after a sampled data bit, to show the frame keeps the settings it started with.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  typedef struct packed {
    logic word9;
    logic par_en;
    logic par_odd;
  } tx_cfg_t;
endpackage

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter  int DATA_W = 9,
  localparam int CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic [DATA_W-1:0] data_i,
  input  tx_cfg_t           cfg_i,
  output logic [DATA_W:0]   frame_o,
  output logic [CNT_W-1:0]  nbits_o
);
  int   n_bits;
  logic par_acc;

  // stop bit and unused upper positions are filled with ones
  always_comb begin
    n_bits  = cfg_i.word9 ? DATA_W : DATA_W - 1;
    par_acc = cfg_i.par_odd;
    frame_o = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n_bits - 1) par_acc = par_acc ^ data_i[i];
      if (i < n_bits) frame_o[i] = data_i[i];
      if (i == n_bits - 1 && cfg_i.par_en) frame_o[i] = par_acc;
    end
    nbits_o = CNT_W'(n_bits);
  end
endmodule

// File: rtl/uart_tx_enable.sv
`timescale 1ns/1ps
module uart_tx_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic busy_i,
  input  logic start_pre_i,
  output logic en_ok_o,
  output logic pre_req_o
);
  logic ready_q, low_seen_q, pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q    <= 1'b0;
      low_seen_q <= 1'b0;
      pre_q      <= 1'b0;
    end else begin
      if (!en_i && !busy_i)    ready_q <= 1'b0;
      else if (tick_i && en_i) ready_q <= 1'b1;

      if (!busy_i)                  low_seen_q <= 1'b0;
      else if (!en_i)               low_seen_q <= 1'b1;
      else if (low_seen_q)          low_seen_q <= 1'b0;

      if (start_pre_i || !busy_i)   pre_q <= 1'b0;
      else if (en_i && low_seen_q)  pre_q <= 1'b1;
    end
  end

  assign en_ok_o   = en_i && ready_q;
  assign pre_req_o = pre_q;

  p_arm_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(tick_i));

  p_pre_in_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_q) |-> busy_i);
endmodule

// File: rtl/uart_tx_shifter.sv
`timescale 1ns/1ps
module uart_tx_shifter #(
  parameter  int DATA_W = 9,
  localparam int CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_ok_i,
  input  logic              pre_req_i,
  input  logic              data_pend_i,
  input  logic [DATA_W:0]   frame_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              tx_o,
  output logic              busy_o,
  output logic              start_data_o,
  output logic              start_pre_o,
  output logic              frame_end_o
);
  logic [DATA_W:0]  shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, line_q, slot;

  // a slot is a tick where the line is free for a new frame
  assign slot         = tick_i && (!busy_q || cnt_q == '0);
  assign start_pre_o  = slot && en_ok_i && pre_req_i;
  assign start_data_o = slot && en_ok_i && !pre_req_i && data_pend_i;
  assign frame_end_o  = tick_i && busy_q && cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b1;
      busy_q  <= 1'b0;
      shreg_q <= '1;
      cnt_q   <= '0;
    end else if (slot) begin
      if (start_pre_o || start_data_o) begin
        busy_q  <= 1'b1;
        cnt_q   <= nbits_i + CNT_W'(1);
        line_q  <= start_pre_o;
        shreg_q <= start_pre_o ? '1 : frame_i;
      end else begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end
    end else if (tick_i && busy_q) begin
      line_q  <= shreg_q[0];
      shreg_q <= {1'b1, shreg_q[DATA_W:1]};
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign tx_o   = line_q;
  assign busy_o = busy_q;

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_data_o |=> !tx_o);

  p_pre_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pre_o |=> tx_o);

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot && !en_ok_i) |=> (tx_o && !busy_q));
endmodule

// File: rtl/uart_tx_msbpar.sv
`timescale 1ns/1ps
module uart_tx_msbpar
  import uart_tx_pkg::*;
#(
  parameter  int DATA_W = 9,
  localparam int CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic              word9_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              txe_ie_i,
  input  logic              tc_ie_i,
  output logic              tx_o,
  output logic              txe_o,
  output logic              tc_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] hold_q;
  logic              txe_q, tc_q;
  tx_cfg_t           cfg;
  logic [DATA_W:0]   frame;
  logic [CNT_W-1:0]  nbits;
  logic              en_ok, pre_req, busy, start_data, start_pre, frame_end;

  assign cfg = '{word9: word9_i, par_en: par_en_i, par_odd: par_odd_i};

  uart_tx_framer #(.DATA_W(DATA_W)) i_framer (
    .data_i (hold_q),
    .cfg_i  (cfg),
    .frame_o(frame),
    .nbits_o(nbits)
  );

  uart_tx_enable i_enable (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (tx_en_i),
    .busy_i     (busy),
    .start_pre_i(start_pre),
    .en_ok_o    (en_ok),
    .pre_req_o  (pre_req)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .en_ok_i     (en_ok),
    .pre_req_i   (pre_req),
    .data_pend_i (!txe_q),
    .frame_i     (frame),
    .nbits_i     (nbits),
    .tx_o        (tx_o),
    .busy_o      (busy),
    .start_data_o(start_data),
    .start_pre_o (start_pre),
    .frame_end_o (frame_end)
  );

  // a write in the same cycle wins over the set conditions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      txe_q  <= 1'b1;
      tc_q   <= 1'b1;
    end else begin
      if (start_data) txe_q <= 1'b1;
      if (frame_end && txe_q && !start_pre) tc_q <= 1'b1;
      if (wr_i) begin
        hold_q <= wdata_i;
        txe_q  <= 1'b0;
        tc_q   <= 1'b0;
      end
    end
  end

  assign txe_o = txe_q;
  assign tc_o  = tc_q;
  assign irq_o = (txe_q && txe_ie_i) || (tc_q && tc_ie_i);

  p_line_on_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(tx_o));

  p_write_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!txe_o && !tc_o));

  p_txe_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txe_o) |-> $past(tick_i));

  p_tc_needs_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> txe_o);
endmodule

// File: tb/test_uart_tx_msbpar.sv
`timescale 1ns/1ps
module test_uart_tx_msbpar;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       tx_en_i = 1'b0, word9_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0;
  logic       wr_i = 1'b0, txe_ie_i = 1'b0, tc_ie_i = 1'b0;
  logic [8:0] wdata_i = '0;
  logic       tx_o, txe_o, tc_o, irq_o;
  logic [1:0] tdiv = '0;
  int         n_chk = 0, n_fail = 0, offtick = 0;
  logic       prev_tx = 1'b1, prev_tick = 1'b0;
  bit         done = 1'b0;

  // {word9, par_en, par_odd, data, expected data positions}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5},
    {1'b1, 1'b0, 1'b0, 9'h1C3, 9'h1C3},
    {1'b0, 1'b1, 1'b0, 9'h007, 9'h087},
    {1'b0, 1'b1, 1'b1, 9'h087, 9'h007},
    {1'b1, 1'b1, 1'b0, 9'h1FF, 9'h0FF},
    {1'b1, 1'b1, 1'b1, 9'h055, 9'h155},
    {1'b0, 1'b1, 1'b0, 9'h000, 9'h000},
    {1'b1, 1'b1, 1'b1, 9'h000, 9'h100}
  };

  always #4 clk = ~clk;

  uart_tx_msbpar i_uart_tx_msbpar (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .tx_en_i(tx_en_i),
    .word9_i(word9_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .txe_ie_i(txe_ie_i), .tc_ie_i(tc_ie_i),
    .tx_o(tx_o), .txe_o(txe_o), .tc_o(tc_o), .irq_o(irq_o)
  );

  // one tick every four clocks
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick_i <= (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (rst_ni && tx_o !== prev_tx && !prev_tick) offtick++;
    prev_tx   = tx_o;
    prev_tick = tick_i;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [8:0] d);
    @(negedge clk);
    wdata_i = d;
    wr_i    = 1'b1;
    @(negedge clk);
    wr_i    = 1'b0;
  endtask

  task automatic wait_start();
    int k = 0;
    while (tx_o && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(!tx_o, "R2 start bit", int'(tx_o), 0);
  endtask

  // called at the first negedge of the start bit
  task automatic read_bits(input int n, input int flip_at,
                           output logic [8:0] bits, output logic stop);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      repeat (4) @(negedge clk);
      bits[i] = tx_o;
      if (i == flip_at) begin
        par_odd_i = ~par_odd_i;
        word9_i   = ~word9_i;
      end
    end
    repeat (4) @(negedge clk);
    stop = tx_o;
  endtask

  initial begin
    logic [8:0] got;
    logic       stp;
    int         k;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_o == 1'b1 && txe_o && tc_o && !irq_o, "R1",
        {tx_o, txe_o, tc_o, irq_o}, 4'b1110);
    txe_ie_i = 1'b1;
    #1 chk(irq_o == 1'b1, "R11 txe enable", int'(irq_o), 1);
    txe_ie_i = 1'b0;
    tc_ie_i  = 1'b1;

    // R8 disabled: word held, line high
    put_word(9'h0A5);
    chk(!txe_o && !tc_o, "R9 R10 write clears flags", {txe_o, tc_o}, 0);
    chk(!irq_o, "R11 flags clear", int'(irq_o), 0);
    k = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!tx_o) k++;
    end
    chk(k == 0 && !txe_o, "R8 no frame while disabled", {k[7:0], txe_o}, 0);

    // R6 enable rises on a tick cycle: first tick arms only
    while (!tick_i) @(negedge clk);
    tx_en_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_o == 1'b1, "R6 no start on arming tick", int'(tx_o), 1);
    @(negedge clk);
    chk(tx_o == 1'b0, "R6 start one bit later", int'(tx_o), 0);
    chk(txe_o == 1'b1, "R9 empty at load", int'(txe_o), 1);
    read_bits(8, -1, got, stp);
    chk(got == 9'h0A5, "R2 first frame bits", got, 9'h0A5);
    chk(stp == 1'b1 && !tc_o, "R10 stop before complete", {stp, tc_o}, 2'b10);
    repeat (4) @(negedge clk);
    chk(tc_o == 1'b1, "R10 complete after stop", int'(tc_o), 1);
    chk(irq_o == 1'b1, "R11 tc enable", int'(irq_o), 1);

    // R3 R4 table of frames
    for (int v = 0; v < 8; v++) begin
      logic [20:0] e;
      int          n;
      e = VEC[v];
      word9_i   = e[20];
      par_en_i  = e[19];
      par_odd_i = e[18];
      n = e[20] ? 9 : 8;
      put_word(e[17:9]);
      wait_start();
      chk(txe_o == 1'b1, "R9 empty at start", int'(txe_o), 1);
      read_bits(n, -1, got, stp);
      chk(got == e[8:0], "R3 R4 data positions", got, e[8:0]);
      chk(stp == 1'b1, "R2 stop bit", int'(stp), 1);
      repeat (4) @(negedge clk);
      chk(tc_o == 1'b1, "R10 complete", int'(tc_o), 1);
    end

    // R5 config change inside a frame
    word9_i = 1'b0; par_en_i = 1'b1; par_odd_i = 1'b0;
    put_word(9'h007);
    wait_start();
    read_bits(8, 2, got, stp);
    chk(got == 9'h087, "R5 frame keeps start config", got, 9'h087);
    chk(stp == 1'b1, "R5 length kept", int'(stp), 1);
    repeat (4) @(negedge clk);
    word9_i = 1'b0; par_en_i = 1'b0; par_odd_i = 1'b0;

    // R7 enable toggle during a frame inserts an idle frame
    put_word(9'h000);
    wait_start();
    put_word(9'h03C);
    tx_en_i = 1'b0;
    @(negedge clk);
    tx_en_i = 1'b1;
    repeat (33) @(negedge clk);
    k = 0;
    while (tx_o && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(k == 44, "R7 idle stretch length", k, 44);
    chk(txe_o == 1'b1, "R9 empty at second start", int'(txe_o), 1);
    read_bits(8, -1, got, stp);
    chk(got == 9'h03C && stp, "R7 word after preamble", got, 9'h03C);
    repeat (8) @(negedge clk);

    chk(offtick == 0, "R12 line moves only after ticks", offtick, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule